// File: doc/BRIEF.md
# PWM Counter Slice

This block is one slice of a pulse-width modulator. A 16-bit counter moves one count on each strobe from an external clock divider and produces two pulse outputs, A and B. Each output is high while the counter is below that channel's compare level, and each can be inverted on its own. In the plain mode the counter climbs to a programmable top value and then restarts at zero. In phase-correct mode it climbs to top and then descends back to zero, which makes the pulses symmetric about the top of the period.

Software programs the slice through a small register port with four registers: control, counter, compare levels and top. Every write applies a per-bit mask, so one field can be changed without disturbing the others. Top and the compare levels are double-buffered while the slice runs, so a new period or duty cycle always starts cleanly at a period boundary. Two self-clearing request bits nudge the phase of a running counter by exactly one count. The advance request adds one extra step. The retard request swallows one strobe. Each time the period closes, the slice raises a sticky interrupt flag and emits a one-cycle DMA request pulse.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter reads 0, both outputs are low, the interrupt flag and DMA request are low, control reads 0, the levels read 0 and top reads 0xFFFF.
- R2: In up mode (control bit 1 clear) each strobe taken while enabled (control bit 0 set) adds one to the counter. A strobe taken when the counter is at or above top sets it to 0 instead, and that step is the wrap.
- R3: In phase-correct mode (control bit 1 set) the counter rises to top and then falls to 0. The wrap is the step that leaves 0 while falling, so with top T the period is 2T strobes.
- R4: Output A is high while the counter is below level A, and output B is high while the counter is below level B. Control bit 2 inverts A and control bit 3 inverts B. A level above top gives an output that stays high.
- R5: The levels register (address 2) holds level A in bits [15:0] and level B in bits [31:16]. A masked write changes only the bits whose mask bit is set, and a read returns the written value.
- R6: While the slice is enabled, new top and level values take effect only at the next wrap. While it is disabled they take effect one cycle after the write.
- R7: While control bit 0 is clear the counter does not move and both outputs hold their level.
- R8: The counter register (address 1) reads the live count. A write to it loads the count directly and overrides any step in that cycle.
- R9: A wrap sets the interrupt flag and drives the DMA request high for the next cycle. The flag stays set until irq_ack is pulsed.
- R10: Writing 1 to control bit 4 requests an advance. In the first enabled cycle without a strobe the counter takes one extra step and the bit clears. While a strobe is present or the slice is disabled the request stays pending and reads back as 1.
- R11: Writing 1 to control bit 5 requests a retard. The next strobe taken while enabled is swallowed without moving the counter, and the bit then clears.
- R12: Register addresses are 0 control, 1 counter, 2 levels and 3 top. Every write stores (old & ~mask) | (data & mask). Control reads back {retard, advance, invert B, invert A, phase-correct, enable} in bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count-enable strobe from the divider |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky wrap interrupt flag |
| dreq | output | 1 | One-cycle DMA request per wrap |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
A corrupted count or direction shows on the outputs in the same cycle, because both pins are compared directly against the counter register. Reading address 1 exposes it at once. A wrong active top or level copy stays hidden until the counter crosses the stale boundary, which can take up to one full period, so the bench runs complete periods after each shadowed write. A stuck advance or retard request shows up as a one-count phase error in the next counter read, and as a bit that never clears in the control read-back.

// File: rtl/pwm_slice_pkg.sv
// Package: shared register addresses and control layout for the PWM slice.
// Assumes a 2-bit register address and a control image that fits in the low
// byte of the write data.
package pwm_slice_pkg;

    // Register addresses on the slice's write/read port.
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_LEVEL = 2'd2,
        REG_TOP   = 2'd3
    } slice_reg_e;

    localparam int CTRL_W  = 6;
    localparam int ADV_POS = 4;
    localparam int RET_POS = 5;

    // Control image, bit 0 (run) is the LSB.
    typedef struct packed {
        logic ret_req;
        logic adv_req;
        logic inv_b;
        logic inv_a;
        logic phase_corr;
        logic run;
    } slice_ctrl_t;

endpackage

// File: rtl/pwm_slice_regs.sv
// Module: register file of the slice. Holds the control bits, the pending
// advance/retard requests, the shadow top and level values and the sticky
// interrupt flag. Every write is merged under a per-bit mask.
// Assumes CNT_W >= CTRL_W so the control image fits in the data word.
module pwm_slice_regs
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [2*CNT_W-1:0]   reg_wdata,
    input  logic [2*CNT_W-1:0]   reg_wmask,
    output logic [2*CNT_W-1:0]   reg_rdata,
    input  logic                 irq_ack,
    input  logic                 wrap,
    input  logic                 adv_done,
    input  logic                 ret_done,
    input  logic [CNT_W-1:0]     cnt,
    output logic                 run,
    output logic                 phase_corr,
    output logic [1:0]           inv,
    output logic                 adv_pend,
    output logic                 ret_pend,
    output logic [CNT_W-1:0]     top_pend,
    output logic [2*CNT_W-1:0]   lvl_pend,
    output logic                 cnt_ld,
    output logic [CNT_W-1:0]     cnt_ld_val,
    output logic                 irq
);

    localparam int DATA_W = 2 * CNT_W;

    logic wr_ctrl, wr_top, wr_lvl;
    logic [CTRL_W-1:0] ctrl_mask, ctrl_data;
    logic [CNT_W-1:0]  lo_mask, lo_data;
    slice_ctrl_t       ctrl_img, ctrl_new;
    logic              adv_set, ret_set;

    // Address decode of the write strobe.
    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_top  = reg_wr && (reg_addr == REG_TOP);
    assign wr_lvl  = reg_wr && (reg_addr == REG_LEVEL);
    assign cnt_ld  = reg_wr && (reg_addr == REG_COUNT);

    assign ctrl_mask = reg_wmask[CTRL_W-1:0];
    assign ctrl_data = reg_wdata[CTRL_W-1:0];
    assign lo_mask   = reg_wmask[CNT_W-1:0];
    assign lo_data   = reg_wdata[CNT_W-1:0];

    // Current control image and its masked update.
    assign ctrl_img = '{ret_req: ret_pend, adv_req: adv_pend, inv_b: inv[1],
                        inv_a: inv[0], phase_corr: phase_corr, run: run};
    assign ctrl_new = slice_ctrl_t'((ctrl_img & ~ctrl_mask) | (ctrl_data & ctrl_mask));

    // Requests are set only by writing a one under the mask.
    assign adv_set = wr_ctrl && ctrl_mask[ADV_POS] && ctrl_new.adv_req;
    assign ret_set = wr_ctrl && ctrl_mask[RET_POS] && ctrl_new.ret_req;

    // Direct counter load value, merged with the live count.
    assign cnt_ld_val = (cnt & ~lo_mask) | (lo_data & lo_mask);

    // Control, shadow and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            phase_corr <= 1'b0;
            inv        <= '0;
            adv_pend   <= 1'b0;
            ret_pend   <= 1'b0;
            top_pend   <= '1;
            lvl_pend   <= '0;
            irq        <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run        <= ctrl_new.run;
                phase_corr <= ctrl_new.phase_corr;
                inv        <= {ctrl_new.inv_b, ctrl_new.inv_a};
            end
            adv_pend <= adv_set | (adv_pend & ~adv_done);
            ret_pend <= ret_set | (ret_pend & ~ret_done);
            if (wr_top) top_pend <= (top_pend & ~lo_mask) | (lo_data & lo_mask);
            if (wr_lvl) lvl_pend <= (lvl_pend & ~reg_wmask) | (reg_wdata & reg_wmask);
            irq <= wrap | (irq & ~irq_ack);
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL:  reg_rdata = DATA_W'(ctrl_img);
            REG_COUNT: reg_rdata = DATA_W'(cnt);
            REG_LEVEL: reg_rdata = lvl_pend;
            default:   reg_rdata = DATA_W'(top_pend);
        endcase
    end

    AST_ADV_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_done && !adv_set) |=> !adv_pend); // R10
    AST_RET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && !ret_set) |=> !ret_pend); // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R9

endmodule

// File: rtl/pwm_slice_counter.sv
// Module: the slice's counter. It steps in up or phase-correct mode, applies
// advance and retard requests, owns the active top and level copies that are
// reloaded at each wrap (or continuously while halted) and registers the DMA
// request. Assumes cnt_tick is a single-cycle strobe from the divider.
module pwm_slice_counter #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_tick,
    input  logic                 run,
    input  logic                 phase_corr,
    input  logic                 adv_pend,
    input  logic                 ret_pend,
    input  logic                 cnt_ld,
    input  logic [CNT_W-1:0]     cnt_ld_val,
    input  logic [CNT_W-1:0]     top_pend,
    input  logic [2*CNT_W-1:0]   lvl_pend,
    output logic [CNT_W-1:0]     cnt,
    output logic [2*CNT_W-1:0]   lvl_act,
    output logic                 wrap,
    output logic                 adv_done,
    output logic                 ret_done,
    output logic                 dreq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] top_act;
    logic             rising;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_rising, nxt_wrap;
    logic             do_step;

    // Qualify the strobe and the phase requests; a direct load wins.
    assign adv_done = !cnt_ld && run && !cnt_tick && adv_pend;
    assign ret_done = !cnt_ld && run && cnt_tick && ret_pend;
    assign do_step  = (!cnt_ld && run && cnt_tick && !ret_pend) || adv_done;
    assign wrap     = do_step && nxt_wrap;

    // Next count and direction for one step in the current mode.
    always_comb begin
        nxt_cnt    = cnt;
        nxt_rising = rising;
        nxt_wrap   = 1'b0;
        if (!phase_corr) begin
            nxt_rising = 1'b1;
            if (cnt >= top_act) begin
                nxt_cnt  = '0;
                nxt_wrap = 1'b1;
            end else begin
                nxt_cnt = cnt + ONE;
            end
        end else if (rising) begin
            if (cnt >= top_act) begin
                if (cnt == '0) begin
                    nxt_wrap = 1'b1;
                end else begin
                    nxt_rising = 1'b0;
                    nxt_cnt    = cnt - ONE;
                end
            end else begin
                nxt_cnt = cnt + ONE;
            end
        end else begin
            if (cnt == '0) begin
                nxt_wrap   = 1'b1;
                nxt_rising = 1'b1;
                nxt_cnt    = (top_act == '0) ? '0 : ONE;
            end else begin
                nxt_cnt = cnt - ONE;
            end
        end
    end

    // Count state, active copies and DMA request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rising  <= 1'b1;
            top_act <= '1;
            lvl_act <= '0;
            dreq    <= 1'b0;
        end else begin
            dreq <= wrap;
            if (cnt_ld) begin
                cnt <= cnt_ld_val;
            end else if (do_step) begin
                cnt    <= nxt_cnt;
                rising <= nxt_rising;
            end
            if (!phase_corr) rising <= 1'b1;
            if (wrap || !run) begin
                top_act <= top_pend;
                lvl_act <= lvl_pend;
            end
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_ld) |=> $stable(cnt)); // R7
    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(top_act) && $stable(lvl_act))); // R6
    AST_RET_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |=> $stable(cnt)); // R11

endmodule

// File: rtl/pwm_slice_chan.sv
// Module: one output channel. The output is high while the count is below the
// channel level, then passes through the channel's polarity control.
// Assumes count and level share one width.
module pwm_slice_chan #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] level,
    input  logic             invert,
    output logic             pwm
);

    // Compare and optional inversion.
    assign pwm = (cnt < level) ^ invert;

endmodule

// File: rtl/pwm_slice.sv
// Module: top of the dual-channel PWM slice. Ties the register file, the
// counter and two compare channels together.
// Assumes the register data width is twice the counter width.
module pwm_slice #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_tick,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [2*CNT_W-1:0]   reg_wdata,
    input  logic [2*CNT_W-1:0]   reg_wmask,
    output logic [2*CNT_W-1:0]   reg_rdata,
    input  logic                 irq_ack,
    output logic                 irq,
    output logic                 dreq,
    output logic                 pwm_a,
    output logic                 pwm_b
);

    localparam int NUM_CH = 2;

    logic                     run, phase_corr, adv_pend, ret_pend;
    logic [NUM_CH-1:0]        inv;
    logic [CNT_W-1:0]         top_pend, cnt, cnt_ld_val;
    logic [NUM_CH*CNT_W-1:0]  lvl_pend, lvl_act;
    logic                     cnt_ld, wrap, adv_done, ret_done;
    logic [NUM_CH-1:0]        pwm_vec;

    pwm_slice_regs #(.CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wmask  (reg_wmask),
        .reg_rdata  (reg_rdata),
        .irq_ack    (irq_ack),
        .wrap       (wrap),
        .adv_done   (adv_done),
        .ret_done   (ret_done),
        .cnt        (cnt),
        .run        (run),
        .phase_corr (phase_corr),
        .inv        (inv),
        .adv_pend   (adv_pend),
        .ret_pend   (ret_pend),
        .top_pend   (top_pend),
        .lvl_pend   (lvl_pend),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .irq        (irq)
    );

    pwm_slice_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_tick   (cnt_tick),
        .run        (run),
        .phase_corr (phase_corr),
        .adv_pend   (adv_pend),
        .ret_pend   (ret_pend),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .top_pend   (top_pend),
        .lvl_pend   (lvl_pend),
        .cnt        (cnt),
        .lvl_act    (lvl_act),
        .wrap       (wrap),
        .adv_done   (adv_done),
        .ret_done   (ret_done),
        .dreq       (dreq)
    );

    // One compare channel per output.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwm_slice_chan #(.CNT_W(CNT_W)) i_chan (
            .cnt    (cnt),
            .level  (lvl_act[ch*CNT_W +: CNT_W]),
            .invert (inv[ch]),
            .pwm    (pwm_vec[ch])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

    AST_DREQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> irq); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr && $stable(inv)) |=> ($stable(pwm_a) && $stable(pwm_b))); // R7

endmodule

// File: tb/test_pwm_slice.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them against the ports.
module test_pwm_slice;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_LVL = 2'd2, A_TOP = 2'd3;
    localparam int S_RD = 0, S_A = 1, S_B = 2, S_IRQ = 3, S_DREQ = 4;
    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] mask;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_wmask = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq, dreq, pwm_a, pwm_b;

    item_t sb[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    int    pc_seq[7] = '{1, 2, 3, 2, 1, 0, 1};

    always #10 clk = ~clk;

    pwm_slice i_pwm_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wmask (reg_wmask),
        .reg_rdata (reg_rdata),
        .irq_ack   (irq_ack),
        .irq       (irq),
        .dreq      (dreq),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b)
    );

    // Monitor: pops expected items and compares them with the ports.
    always begin
        @(chk_ev);
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] obs;
            it = sb.pop_front();
            case (it.sel)
                S_RD:    obs = reg_rdata;
                S_A:     obs = {31'b0, pwm_a};
                S_B:     obs = {31'b0, pwm_b};
                S_IRQ:   obs = {31'b0, irq};
                default: obs = {31'b0, dreq};
            endcase
            n_chk++;
            if ((obs & it.mask) !== it.exp) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", it.req, obs & it.mask, it.exp);
            end
        end
    end

    task automatic push_item(input int sel, input logic [31:0] m, input logic [31:0] e,
                             input string req);
        item_t it;
        it.sel = sel; it.mask = m; it.exp = e; it.req = req;
        sb.push_back(it);
        -> chk_ev;
        #0.2;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [31:0] m, input logic [31:0] e,
                           input string req);
        reg_addr = a;
        #0.2;
        push_item(S_RD, m, e, req);
    endtask

    task automatic chk_pin(input int sel, input logic e, input string req);
        push_item(sel, 32'h1, {31'b0, e}, req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [31:0] m);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
        @(negedge clk);
        reg_wr = 1'b0; reg_wmask = '0;
    endtask

    task automatic step(input logic tk);
        cnt_tick = tk;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg(A_CNT, 32'hFFFF, 0, "R1 count");
        chk_pin(S_A, 1'b0, "R1 pwm_a");
        chk_pin(S_B, 1'b0, "R1 pwm_b");
        chk_pin(S_IRQ, 1'b0, "R1 irq");
        chk_pin(S_DREQ, 1'b0, "R1 dreq");
        chk_reg(A_TOP, 32'hFFFF, 32'hFFFF, "R1 top");
        chk_reg(A_CTRL, 32'h3F, 0, "R1 ctrl");
        chk_reg(A_LVL, ALL, 0, "R1 levels");

        // R2 up mode, R4 compare, R9 wrap events
        wr(A_TOP, 32'd3, 32'hFFFF);
        wr(A_LVL, 32'h0002_0001, ALL);
        wr(A_CTRL, 32'h1, 32'h1);
        chk_reg(A_CTRL, 32'h3F, 32'h1, "R12 ctrl readback");
        chk_reg(A_CNT, 32'hFFFF, 0, "R2 start");
        chk_pin(S_A, 1'b1, "R4 a at 0");
        chk_pin(S_B, 1'b1, "R4 b at 0");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 1, "R2 count 1");
        chk_pin(S_A, 1'b0, "R4 a at 1");
        chk_pin(S_B, 1'b1, "R4 b at 1");
        step(1);
        chk_pin(S_B, 1'b0, "R4 b at 2");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 3, "R2 count top");
        chk_pin(S_DREQ, 1'b0, "R9 no dreq before wrap");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 0, "R2 wrap to 0");
        chk_pin(S_DREQ, 1'b1, "R9 dreq on wrap");
        chk_pin(S_IRQ, 1'b1, "R9 irq on wrap");
        step(0);
        chk_pin(S_DREQ, 1'b0, "R9 dreq one cycle");
        chk_pin(S_IRQ, 1'b1, "R9 irq sticky");
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk_pin(S_IRQ, 1'b0, "R9 irq cleared");

        // R5 masked level write, R6 shadowing while running
        step(1);
        wr(A_TOP, 32'd5, 32'hFFFF);
        wr(A_LVL, 32'h0000_0004, 32'h0000_FFFF);
        chk_reg(A_LVL, ALL, 32'h0002_0004, "R5 low field only");
        chk_pin(S_A, 1'b0, "R6 old level A kept");
        step(1); step(1); step(1);
        chk_reg(A_CNT, 32'hFFFF, 0, "R6 old top kept");
        step(1);
        chk_pin(S_A, 1'b1, "R6 new level A at 1");
        step(1); step(1); step(1);
        chk_reg(A_CNT, 32'hFFFF, 4, "R6 passes old top");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 5, "R6 new top reached");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 0, "R6 wrap at new top");

        // R4 inversion and level above top
        wr(A_LVL, 32'h0010_0000, 32'hFFFF_0000);
        chk_reg(A_LVL, ALL, 32'h0010_0004, "R5 high field only");
        wr(A_CTRL, 32'h4, 32'h4);
        chk_pin(S_A, 1'b0, "R4 inverted a at 0");
        for (int i = 0; i < 11; i++) step(1);
        chk_reg(A_CNT, 32'hFFFF, 5, "R2 count 5");
        chk_pin(S_B, 1'b1, "R4 level above top high");
        chk_pin(S_A, 1'b1, "R4 inverted a at 5");

        // R7 halt
        wr(A_CTRL, 32'h0, 32'h1);
        step(1); step(1); step(1);
        chk_reg(A_CNT, 32'hFFFF, 5, "R7 count held");
        chk_pin(S_A, 1'b1, "R7 a held");
        chk_pin(S_B, 1'b1, "R7 b held");
        chk_reg(A_CTRL, 32'h3F, 32'h4, "R12 masked ctrl");

        // R8 direct counter write
        wr(A_CNT, 32'd2, 32'hFFFF);
        chk_reg(A_CNT, 32'hFFFF, 2, "R8 count loaded");

        // R3 phase-correct
        wr(A_TOP, 32'd3, 32'hFFFF);
        wr(A_CNT, 32'd0, 32'hFFFF);
        wr(A_CTRL, 32'h3, 32'h7);
        for (int i = 0; i < 7; i++) begin
            step(1);
            chk_reg(A_CNT, 32'hFFFF, pc_seq[i], "R3 up/down count");
            if (i == 5) chk_pin(S_DREQ, 1'b0, "R3 no wrap entering 0");
            if (i == 6) chk_pin(S_DREQ, 1'b1, "R3 wrap leaving 0");
        end

        // R10 advance
        wr(A_CTRL, 32'h0, 32'h2);
        wr(A_CNT, 32'd0, 32'hFFFF);
        wr(A_CTRL, 32'h10, 32'h10);
        chk_reg(A_CTRL, 32'h10, 32'h10, "R10 request pending");
        step(0);
        chk_reg(A_CNT, 32'hFFFF, 1, "R10 extra count");
        chk_reg(A_CTRL, 32'h10, 0, "R10 self clear");
        wr(A_CTRL, 32'h10, 32'h10);
        step(1); step(1);
        chk_reg(A_CNT, 32'hFFFF, 3, "R10 ticks only");
        chk_reg(A_CTRL, 32'h10, 32'h10, "R10 held under strobe");
        step(0);
        chk_reg(A_CNT, 32'hFFFF, 0, "R10 advance wraps");
        chk_pin(S_DREQ, 1'b1, "R10 wrap by advance");

        // R11 retard
        wr(A_CTRL, 32'h20, 32'h20);
        step(0);
        chk_reg(A_CTRL, 32'h20, 32'h20, "R11 waits for strobe");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 0, "R11 strobe swallowed");
        chk_reg(A_CTRL, 32'h20, 0, "R11 self clear");
        step(1);
        chk_reg(A_CNT, 32'hFFFF, 1, "R11 counting resumes");

        // R10 request held while disabled
        wr(A_CTRL, 32'h0, 32'h1);
        wr(A_CTRL, 32'h10, 32'h10);
        step(0); step(0);
        chk_reg(A_CTRL, 32'h10, 32'h10, "R10 pending while halted");
        chk_reg(A_CNT, 32'hFFFF, 1, "R10 no step while halted");
        wr(A_CTRL, 32'h1, 32'h1);
        chk_reg(A_CNT, 32'hFFFF, 1, "R10 not applied on enable edge");
        step(0);
        chk_reg(A_CNT, 32'hFFFF, 2, "R10 applied after enable");

        #1;
        done = 1'b1;
        report();
        $finish;
    end

endmodule